// File: doc/BRIEF.md
# Chainable Multiply-Accumulate Filter Array

This block is a fixed-length multiply-accumulate pipeline for streaming FIR work such as two-dimensional image kernels. It takes one signed 16-bit sample on every clock. It multiplies that sample by 32 per-tap signed 8-bit weights, and each cycle it returns one accumulated sum of products over the most recent 32 samples. Weights are loaded one at a time through a plain write port (enable, 5-bit tap index, 8-bit value).

A second stream, the chain input, is held back by 32 clocks and added to the scaled array result. The scaled output of one instance can therefore drive the chain input of the next, so several instances together form a longer filter with the same scaling at every stage. A 2-bit window select scales the wide internal sum down to the 16-bit output. Overflow in the window or in the chain adder clips the value and latches a flag. Either flag pulls an active-low error line low.

Top module: `mac_cascade_array`

## Requirements
- R1: While reset is applied and right after it: `dout` is 0, `dout_valid` is low, both overflow flags are low, `err_n` is high, and all 32 weights are zero. With zero weights, nonzero samples produce a zero output.
- R2: When `coef_we` is high at a rising edge, the signed 8-bit `coef_data` becomes weight W[`coef_addr`] from the next edge on. W[0] multiplies the newest sample and W[31] multiplies the oldest sample.
- R3: The output registered at edge t+1 is the windowed value of the sum, for k = 0..31, of W[k]·x[t−k], where x[t] is the sample taken at edge t and samples before reset count as zero. After reset the sum therefore grows one term per sample and is complete from the 32nd sample onward.
- R4: A tap whose weight is zero only passes the partial sum along. With W[31] = 1 and all other weights 0, a sample taken at edge t appears unchanged on the output registered at edge t+32.
- R5: `out_sel` = s shifts the internal sum right arithmetically (rounding toward minus infinity) by 4·s bits, and the low 16 bits of the result form the windowed value.
- R6: If the shifted sum is outside −32768..32767, the windowed value clips to the nearer limit and `sel_ovf` rises on the same output edge.
- R7: A `cas_in` value taken at edge s is added to the windowed value in the output registered at edge s+32, and not earlier.
- R8: If that addition is outside −32768..32767, the output clips to the nearer limit and `cas_ovf` rises on the same output edge.
- R9: `sel_ovf` and `cas_ovf` stay set until reset. `err_n` is low exactly when either flag is set.
- R10: `dout_valid` is low for the first 32 output edges after reset is released. It rises on the output registered at the 33rd rising edge, when 32 samples have entered, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 16 | Signed sample, one per clock |
| coef_we | input | 1 | Weight write enable |
| coef_addr | input | 5 | Tap index of the weight to write |
| coef_data | input | 8 | Signed weight value |
| out_sel | input | 2 | Output window select, shift of 4·value bits |
| cas_in | input | 16 | Signed chain input from an upstream instance |
| dout | output | 16 | Signed scaled result, registered |
| dout_valid | output | 1 | High once a full 32-sample window has entered |
| sel_ovf | output | 1 | Sticky window overflow flag |
| cas_ovf | output | 1 | Sticky chain adder overflow flag |
| err_n | output | 1 | Active-low error, low when either flag is set |

## Verification
A corrupted partial sum in any tap reaches `dout` on the next edge when it is at tap 0. When it is further up the chain, it arrives one cycle later for each tap between it and the output, so the error can stay out of sight for up to 31 cycles. An impulse through a single far tap therefore checks every carry stage at once. A fault in the chain delay shows only as a cascade value that arrives one edge early or one edge late, so that arrival edge is checked exactly. Window or clipping faults show at once as wrong output values or as a flag that fails to rise, and a flag that is not sticky shows on the first quiet cycle after an overflow.

// File: rtl/mac_cascade_pkg.sv
package mac_cascade_pkg;

   localparam int MCA_TAPS     = 32;
   localparam int MCA_DATA_W   = 16;
   localparam int MCA_COEF_W   = 8;
   localparam int MCA_ACC_W    = 36;
   localparam int MCA_OUT_W    = 16;
   localparam int MCA_SEL_W    = 2;
   localparam int MCA_SEL_STEP = 4;

   typedef struct packed {
      logic win_ovf;
      logic chain_ovf;
   } mca_flags_t;

endpackage

// File: rtl/mca_coef_bank.sv
module mca_coef_bank #(
   parameter int TAPS   = 32,
   parameter int COEF_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [COEF_W-1:0]              wdata,
   output logic [TAPS-1:0][COEF_W-1:0]    weights
);

   for (genvar k = 0; k < TAPS; k++) begin : g_wt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            weights[k] <= '0;
         end else if (we && (addr == ADDR_W'(k))) begin
            weights[k] <= wdata;
         end
      end
   end

endmodule

// File: rtl/mca_tap_chain.sv
module mca_tap_chain #(
   parameter int TAPS   = 32,
   parameter int DATA_W = 16,
   parameter int COEF_W = 8,
   parameter int ACC_W  = 36
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic signed [DATA_W-1:0]     din,
   input  logic [TAPS-1:0][COEF_W-1:0]  weights,
   output logic signed [ACC_W-1:0]      acc_out
);

   localparam int PROD_W = DATA_W + COEF_W;
   localparam int EXT_W  = ACC_W - PROD_W;

   // Transposed form: every tap sees the same sample, partial sums move
   // toward tap 0, which holds the finished result.
   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      logic signed [PROD_W-1:0] prod;
      logic signed [ACC_W-1:0]  prod_ext;
      logic signed [ACC_W-1:0]  q;

      assign prod     = din * $signed(weights[k]);
      assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

      if (k == TAPS - 1) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= prod_ext;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_tap[k+1].q + prod_ext;
         end
      end
   end

   assign acc_out = g_tap[0].q;

endmodule

// File: rtl/mca_delay_line.sv
module mca_delay_line #(
   parameter int DEPTH = 32,
   parameter int W     = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_multi
      logic [DEPTH-1:0][W-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[DEPTH-2:0], d};
      end
      assign q = sr[DEPTH-1];
   end

endmodule

// File: rtl/mca_out_window.sv
module mca_out_window
   import mac_cascade_pkg::*;
#(
   parameter int ACC_W    = 36,
   parameter int OUT_W    = 16,
   parameter int SEL_W    = 2,
   parameter int SEL_STEP = 4
) (
   input  logic signed [ACC_W-1:0]  acc,
   input  logic [SEL_W-1:0]         sel,
   input  logic signed [OUT_W-1:0]  chain,
   output logic signed [OUT_W-1:0]  result,
   output mca_flags_t               flags
);

   localparam int HI_W = ACC_W - OUT_W + 1;
   localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

   int unsigned              shamt;
   logic signed [ACC_W-1:0]  shifted;
   logic [HI_W-1:0]          hi;
   logic signed [OUT_W-1:0]  win;
   logic signed [OUT_W:0]    sum;

   always_comb begin
      shamt   = 32'(sel) * SEL_STEP;
      shifted = acc >>> shamt;
      hi      = shifted[ACC_W-1:OUT_W-1];
      flags.win_ovf = !((&hi) || (~|hi));
      if (flags.win_ovf) win = shifted[ACC_W-1] ? NEG_LIM : POS_LIM;
      else               win = shifted[OUT_W-1:0];

      sum = {win[OUT_W-1], win} + {chain[OUT_W-1], chain};
      flags.chain_ovf = (sum[OUT_W] != sum[OUT_W-1]);
      if (flags.chain_ovf) result = sum[OUT_W] ? NEG_LIM : POS_LIM;
      else                 result = sum[OUT_W-1:0];
   end

endmodule

// File: rtl/mac_cascade_array.sv
module mac_cascade_array
   import mac_cascade_pkg::*;
#(
   parameter int TAPS     = MCA_TAPS,
   parameter int DATA_W   = MCA_DATA_W,
   parameter int COEF_W   = MCA_COEF_W,
   parameter int ACC_W    = MCA_ACC_W,
   parameter int OUT_W    = MCA_OUT_W,
   parameter int SEL_W    = MCA_SEL_W,
   parameter int SEL_STEP = MCA_SEL_STEP,
   localparam int ADDR_W  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic signed [DATA_W-1:0]  din,
   input  logic                      coef_we,
   input  logic [ADDR_W-1:0]         coef_addr,
   input  logic [COEF_W-1:0]         coef_data,
   input  logic [SEL_W-1:0]          out_sel,
   input  logic signed [OUT_W-1:0]   cas_in,
   output logic signed [OUT_W-1:0]   dout,
   output logic                      dout_valid,
   output logic                      sel_ovf,
   output logic                      cas_ovf,
   output logic                      err_n
);

   localparam int CNT_W     = $clog2(TAPS + 1);
   localparam int GROWTH    = (TAPS > 1) ? $clog2(TAPS) : 0;
   localparam int MAX_SHIFT = ((1 << SEL_W) - 1) * SEL_STEP;

   if (ACC_W < DATA_W + COEF_W + GROWTH) begin : g_chk_acc
      $error("mac_cascade_array: ACC_W too narrow for full-precision sums");
   end
   if (OUT_W > ACC_W) begin : g_chk_out
      $error("mac_cascade_array: OUT_W exceeds ACC_W");
   end
   if (MAX_SHIFT + OUT_W > ACC_W) begin : g_chk_sel
      $error("mac_cascade_array: window shift range exceeds ACC_W");
   end
   if (TAPS < 2) begin : g_chk_taps
      $error("mac_cascade_array: TAPS must be at least 2");
   end

   logic [TAPS-1:0][COEF_W-1:0] weights;
   logic signed [ACC_W-1:0]     acc;
   logic signed [OUT_W-1:0]     chain_d;
   logic signed [OUT_W-1:0]     result;
   mca_flags_t                  flags_now;
   mca_flags_t                  flags_q;
   logic [CNT_W-1:0]            seen;

   mca_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(coef_we), .addr(coef_addr),
      .wdata(coef_data), .weights(weights)
   );

   mca_tap_chain #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_chain (
      .clk(clk), .rst_n(rst_n), .din(din), .weights(weights), .acc_out(acc)
   );

   // The array adds one register ahead of the output stage; the chain
   // input is held TAPS cycles so it lands on the edge after TAPS stages.
   mca_delay_line #(.DEPTH(TAPS), .W(OUT_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .d(cas_in), .q(chain_d)
   );

   mca_out_window #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SEL_W(SEL_W), .SEL_STEP(SEL_STEP)) u_win (
      .acc(acc), .sel(out_sel), .chain(chain_d), .result(result), .flags(flags_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= '0;
         flags_q <= '0;
      end else begin
         dout              <= result;
         flags_q.win_ovf   <= flags_q.win_ovf   | flags_now.win_ovf;
         flags_q.chain_ovf <= flags_q.chain_ovf | flags_now.chain_ovf;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen       <= '0;
         dout_valid <= 1'b0;
      end else begin
         if (seen != CNT_W'(TAPS)) seen <= seen + 1'b1;
         dout_valid <= dout_valid | (seen == CNT_W'(TAPS));
      end
   end

   assign sel_ovf = flags_q.win_ovf;
   assign cas_ovf = flags_q.chain_ovf;
   assign err_n   = ~(flags_q.win_ovf | flags_q.chain_ovf);

endmodule

// File: rtl/mac_cascade_array_chk.sv
module mac_cascade_array_chk #(
   parameter int TAPS = 32
) (
   input logic clk,
   input logic rst_n,
   input logic dout_valid,
   input logic sel_ovf,
   input logic cas_ovf,
   input logic err_n
);

   localparam int CW = $clog2(TAPS + 2) + 1;
   logic [CW-1:0] edges;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        edges <= '0;
      else if (edges != CW'(TAPS + 1))   edges <= edges + 1'b1;
   end

   assert_valid_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid == (edges > CW'(TAPS)));

   assert_valid_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |=> dout_valid);

   assert_win_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ovf |=> sel_ovf);

   assert_chain_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cas_ovf |=> cas_ovf);

   assert_err_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !err_n |=> !err_n);

endmodule

bind mac_cascade_array mac_cascade_array_chk #(.TAPS(TAPS)) u_chk (
   .clk(clk), .rst_n(rst_n), .dout_valid(dout_valid),
   .sel_ovf(sel_ovf), .cas_ovf(cas_ovf), .err_n(err_n)
);

// File: tb/mac_cascade_array_test.sv
`timescale 1ns/1ps
module mac_cascade_array_test;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [15:0] din = '0;
   logic               coef_we = 1'b0;
   logic [4:0]         coef_addr = '0;
   logic [7:0]         coef_data = '0;
   logic [1:0]         out_sel = '0;
   logic signed [15:0] cas_in = '0;
   logic signed [15:0] dout;
   logic               dout_valid, sel_ovf, cas_ovf, err_n;

   int checks = 0;
   int errors = 0;
   int cm [32];
   int xs [128];
   int cs [128];
   int sel_m = 0;

   // {sample, expected output} with W[0]=2, W[1]=-3, window 0
   localparam int VEC [8][2] = '{
      '{5, 10}, '{-7, -29}, '{100, 221}, '{0, -300},
      '{1000, 2000}, '{-9000, -21000}, '{-4000, 19000}, '{3, 12006}};

   always #2.5 clk = ~clk;

   mac_cascade_array uut (
      .clk(clk), .rst_n(rst_n), .din(din), .coef_we(coef_we),
      .coef_addr(coef_addr), .coef_data(coef_data), .out_sel(out_sel),
      .cas_in(cas_in), .dout(dout), .dout_valid(dout_valid),
      .sel_ovf(sel_ovf), .cas_ovf(cas_ovf), .err_n(err_n)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; din = '0; cas_in = '0; coef_we = 1'b0; out_sel = '0;
      for (int k = 0; k < 32; k++) cm[k] = 0;
      for (int k = 0; k < 128; k++) begin xs[k] = 0; cs[k] = 0; end
      sel_m = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input int a, input int v);
      coef_we = 1'b1; coef_addr = 5'(a); coef_data = 8'(v);
      @(negedge clk);
      coef_we = 1'b0;
      cm[a] = v;
   endtask

   function automatic longint clip(input longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic longint model(input int t);
      longint a = 0;
      for (int k = 0; k < 32; k++)
         if (t - k >= 0) a += longint'(cm[k]) * xs[t-k];
      a = clip(a >>> (sel_m * 4));
      if (t - 31 >= 0) a += cs[t-31];
      return clip(a);
   endfunction

   task automatic run_stream(input int n, input string tag);
      for (int j = 0; j < n + 35; j++) begin
         @(negedge clk);
         if (j >= 2) chk(tag, dout, model(j - 2));
         din    = (j < n) ? 16'(xs[j]) : '0;
         cas_in = (j < n) ? 16'(cs[j]) : '0;
      end
   endtask

   initial begin
      #750000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      chk("R1 dout", dout, 0);
      chk("R1 valid", dout_valid, 0);
      chk("R1 flags", {sel_ovf, cas_ovf}, 0);
      chk("R1 err_n", err_n, 1);

      // R10 and R1: valid timing; zero weights give zero output
      do_reset();
      din = 16'sd1234; cas_in = '0;
      repeat (32) @(negedge clk);
      chk("R10 valid before 33rd edge", dout_valid, 0);
      chk("R1 zero weights", dout, 0);
      @(negedge clk);
      chk("R10 valid at 33rd edge", dout_valid, 1);
      repeat (5) @(negedge clk);
      chk("R10 valid holds", dout_valid, 1);

      // R2 R3: vector table with two taps
      do_reset();
      wr(0, 2); wr(1, -3);
      for (int j = 0; j < 10; j++) begin
         @(negedge clk);
         if (j >= 2) chk("R3 table", dout, VEC[j-2][1]);
         din = (j < 8) ? 16'(VEC[j][0]) : '0;
      end

      // R3: full 32-term sums, window 0 then window 1 (R5)
      for (int pass = 0; pass < 2; pass++) begin
         do_reset();
         for (int k = 0; k < 32; k++) wr(k, k - 13);
         out_sel = 2'(pass); sel_m = pass;
         for (int j = 0; j < 40; j++) xs[j] = ((j * 37) % 201) - 100;
         run_stream(40, pass == 0 ? "R3 full window" : "R5 shift 4");
      end

      // R4 R2: impulse through the far tap only
      do_reset();
      wr(31, 1);
      xs[0] = 500;
      run_stream(1, "R4 far tap");

      // R5: floor shift by 12
      do_reset();
      wr(0, 127); out_sel = 2'd3;
      din = 16'sd30000;
      repeat (2) @(negedge clk);
      chk("R5 shift 12 pos", dout, 930);
      din = -16'sd30000;
      repeat (2) @(negedge clk);
      chk("R5 shift 12 neg floor", dout, -931);
      chk("R5 no overflow", sel_ovf, 0);

      // R6 R9: window clip, sticky flag, error line
      do_reset();
      wr(0, 127);
      din = 16'sd300;
      repeat (2) @(negedge clk);
      chk("R6 clip high", dout, 32767);
      chk("R6 flag", sel_ovf, 1);
      chk("R9 err_n", err_n, 0);
      din = '0;
      repeat (2) @(negedge clk);
      chk("R9 output recovers", dout, 0);
      chk("R9 flag sticky", sel_ovf, 1);
      din = -16'sd300;
      repeat (2) @(negedge clk);
      chk("R6 clip low", dout, -32768);

      // R7 R8: chain delay and chain overflow
      do_reset();
      wr(0, 127);
      din = 16'sd250; cas_in = 16'sd2000;
      repeat (5) @(negedge clk);
      chk("R7 chain not yet", dout, 31750);
      repeat (27) @(negedge clk);
      chk("R7 chain one edge early", dout, 31750);
      chk("R8 flag clear before", cas_ovf, 0);
      @(negedge clk);
      chk("R8 chain clip", dout, 32767);
      chk("R8 chain flag", cas_ovf, 1);
      chk("R8 window flag clear", sel_ovf, 0);
      chk("R9 err_n chain", err_n, 0);

      // R7: mixed array and chain streams
      do_reset();
      wr(0, 3);
      for (int j = 0; j < 50; j++) begin
         xs[j] = ((j * 11) % 61) - 30;
         cs[j] = ((j * 53) % 401) - 200;
      end
      run_stream(50, "R7 chain stream");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule